// File: doc/BRIEF.md
# Multifunction 32-bit ALU

This block is a purely combinational 32-bit arithmetic and logic unit. It takes two operands, a 5-bit shift amount and four small control fields, and in the same cycle returns a 32-bit result together with sign, zero and overflow status flags. A 2-bit group select picks the source of the result: the barrel shifter, the signed set-less-than compare, the adder/subtractor, or the bitwise logic unit.

The shifter handles all four shift and rotate kinds with a single right-shifting network. First the operand is widened to 63 bits, and the fill depends on the operation. The widened word then passes through one stage per shift-amount bit. A left shift runs through the same network using the bitwise complement of the amount.

The compare group always drives the adder into subtraction, whatever the add/subtract control says. It then takes sign XOR overflow of the difference, so the answer is correct even when the subtraction overflows.

Top module: `alu_top`

## Requirements
- R1: With groupSel = 2'b11 the result is the bitwise function of opA and opB chosen by logicOp: 2'b00 AND, 2'b01 OR, 2'b10 NOR, 2'b11 XOR.
- R2: With groupSel = 2'b10 the result is opA + opB modulo 2^32 when subCtl = 0, and opA - opB modulo 2^32 when subCtl = 1.
- R3: ovfFlag is 1 exactly when the signed two's-complement result of the adder operation in force does not fit in 32 bits. That operation is subtraction in the compare group, and the one chosen by subCtl otherwise.
- R4: signFlag equals bit 31 of the adder output, which is the 32-bit sum or difference of the adder operation in force.
- R5: With groupSel = 2'b01 the result is 32'd1 when opA is less than opB as signed 32-bit numbers, and 32'd0 otherwise. The result does not depend on subCtl.
- R6: With groupSel = 2'b00 and shiftOp = 2'b00, the result is opA shifted left by shAmt with zeros filled in.
- R7: With groupSel = 2'b00, shiftOp = 2'b01 shifts opA right logically, with zero fill. shiftOp = 2'b10 shifts it right arithmetically, copying bit 31 into the vacated bits. shiftOp = 2'b11 rotates it right. In each case the distance is shAmt, from 0 to 31.
- R8: zeroFlag is 1 exactly when all 32 bits of the selected result are 0, in every group.
- R9: In the shift group the result depends only on opA, shAmt and shiftOp. opB, subCtl and logicOp have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; also the data that is shifted |
| opB | input | 32 | Second operand |
| shAmt | input | 5 | Shift or rotate distance |
| logicOp | input | 2 | Bitwise function select |
| subCtl | input | 1 | 0 add, 1 subtract |
| shiftOp | input | 2 | 00 left, 01 right logical, 10 right arithmetic, 11 rotate right |
| groupSel | input | 2 | 00 shift, 01 set-less-than, 10 arithmetic, 11 logic |
| result | output | 32 | Selected result |
| signFlag | output | 1 | Bit 31 of the adder output |
| zeroFlag | output | 1 | Result is all zeros |
| ovfFlag | output | 1 | Signed overflow of the adder |

## Verification
The block holds no state, so a wrong internal decision shows at the ports in the same evaluation as the stimulus that exposes it. A mis-wired shifter stage is exposed only by the shift amounts that use that stage, so the bench sweeps all 32 distances for every shift kind. The compare and flag paths fail only for particular operand sign combinations. For these paths the bench crosses a set of signed corner values, including the most negative number, against each other with both settings of the add/subtract control.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_SLT   = 2'b01,
    GRP_ARITH = 2'b10,
    GRP_LOGIC = 2'b11
  } aluGroup_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_NOR = 2'b10,
    LOP_XOR = 2'b11
  } logicOp_e;

  typedef enum logic [1:0] {
    SOP_SLL = 2'b00,
    SOP_SRL = 2'b01,
    SOP_SRA = 2'b10,
    SOP_ROR = 2'b11
  } shiftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic selShift;
    logic selSlt;
    logic selArith;
    logic selLogic;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0]  groupSel,
  input  logic        subCtl,
  output aluStrobes_t strobes
);

  logic forceSub;

  always_comb begin
    strobes  = '0;
    forceSub = 1'b0;
    case (groupSel)
      GRP_SHIFT: strobes.selShift = 1'b1;
      GRP_SLT: begin
        strobes.selSlt = 1'b1;
        forceSub       = 1'b1;
      end
      GRP_ARITH: strobes.selArith = 1'b1;
      default:   strobes.selLogic = 1'b1;
    endcase
    strobes.invertB = subCtl | forceSub;
    strobes.carryIn = subCtl | forceSub;
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invertB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);

  logic [WIDTH-1:0] bEff;

  always_comb begin
    bEff = invertB ? ~b : b;
    sum  = a + bEff + {{(WIDTH-1){1'b0}}, carryIn};
    // same-signed inputs producing a differently signed output
    ovf  = (a[WIDTH-1] == bEff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data,
  input  logic [SHW-1:0]   amount,
  input  logic [1:0]       shiftOp,
  output logic [WIDTH-1:0] shifted
);

  localparam int EXTW = 2 * WIDTH - 1;

  logic [EXTW-1:0] extData;
  logic [SHW-1:0]  rightAmt;
  logic [EXTW-1:0] stage [SHW+1];

  always_comb begin
    case (shiftOp)
      SOP_SLL: extData = {data, {(WIDTH-1){1'b0}}};
      SOP_SRL: extData = {{(WIDTH-1){1'b0}}, data};
      SOP_SRA: extData = {{(WIDTH-1){data[WIDTH-1]}}, data};
      default: extData = {data[WIDTH-2:0], data};
    endcase
    // a left shift by n equals a right shift of the widened word by WIDTH-1-n
    rightAmt = (shiftOp == SOP_SLL) ? ~amount : amount;
  end

  assign stage[0] = extData;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    assign stage[i+1] = rightAmt[i] ? (stage[i] >> (1 << i)) : stage[i];
  end

  assign shifted = stage[SHW][WIDTH-1:0];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  logic [1:0]       logicOp,
  input  logic [1:0]       shiftOp,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             signFlag,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  logic [WIDTH-1:0] sumOut;
  logic             sumOvf;
  logic [WIDTH-1:0] shiftOut;
  logic [WIDTH-1:0] logicOut;
  logic [WIDTH-1:0] sltOut;

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a       (opA),
    .b       (opB),
    .invertB (strobes.invertB),
    .carryIn (strobes.carryIn),
    .sum     (sumOut),
    .ovf     (sumOvf)
  );

  alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shifter (
    .data    (opA),
    .amount  (shAmt),
    .shiftOp (shiftOp),
    .shifted (shiftOut)
  );

  always_comb begin
    case (logicOp)
      LOP_AND: logicOut = opA & opB;
      LOP_OR:  logicOut = opA | opB;
      LOP_NOR: logicOut = ~(opA | opB);
      default: logicOut = opA ^ opB;
    endcase
  end

  assign sltOut = {{(WIDTH-1){1'b0}}, sumOut[WIDTH-1] ^ sumOvf};

  always_comb begin
    result = ({WIDTH{strobes.selShift}} & shiftOut)
           | ({WIDTH{strobes.selSlt}}   & sltOut)
           | ({WIDTH{strobes.selArith}} & sumOut)
           | ({WIDTH{strobes.selLogic}} & logicOut);
  end

  assign signFlag = sumOut[WIDTH-1];
  assign ovfFlag  = sumOvf;
  assign zeroFlag = ~|result;

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  logic [1:0]       logicOp,
  input  logic             subCtl,
  input  logic [1:0]       shiftOp,
  input  logic [1:0]       groupSel,
  output logic [WIDTH-1:0] result,
  output logic             signFlag,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .groupSel (groupSel),
    .subCtl   (subCtl),
    .strobes  (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH), .SHW(SHW)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .shAmt    (shAmt),
    .logicOp  (logicOp),
    .shiftOp  (shiftOp),
    .strobes  (strobes),
    .result   (result),
    .signFlag (signFlag),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: rtl/alu_top_chk.sv
module alu_top_chk #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [SHW-1:0]   shAmt,
  input logic [1:0]       logicOp,
  input logic             subCtl,
  input logic [1:0]       shiftOp,
  input logic [1:0]       groupSel,
  input logic [WIDTH-1:0] result,
  input logic             signFlag,
  input logic             zeroFlag,
  input logic             ovfFlag
);

  logic             known;
  logic [WIDTH-1:0] logicRef;
  logic [WIDTH-1:0] diff;

  always_comb begin
    known = !$isunknown({opA, opB, shAmt, logicOp, subCtl, shiftOp, groupSel});
    diff  = opA - opB;
    case (logicOp)
      2'b00:   logicRef = opA & opB;
      2'b01:   logicRef = opA | opB;
      2'b10:   logicRef = ~(opA | opB);
      default: logicRef = opA ^ opB;
    endcase

    if (known) begin
      // R1 logic group
      a_r1_logic: assert (groupSel != 2'b11 || result == logicRef);
      // R2 arithmetic group
      a_r2_arith: assert (groupSel != 2'b10 ||
                          result == (subCtl ? diff : opA + opB));
      // R3 overflow on addition in arithmetic group
      a_r3_add_overflow: assert (groupSel != 2'b10 || subCtl ||
        ovfFlag == ((opA[WIDTH-1] == opB[WIDTH-1]) && (result[WIDTH-1] != opA[WIDTH-1])));
      // R4 sign follows the arithmetic output
      a_r4_sign: assert (groupSel != 2'b10 || signFlag == result[WIDTH-1]);
      // R5 compare result
      a_r5_slt: assert (groupSel != 2'b01 ||
                        result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))});
      // R5 compare forces subtraction regardless of subCtl
      a_r5_slt_sign: assert (groupSel != 2'b01 || signFlag == diff[WIDTH-1]);
      // R7 rotate right
      a_r7_rotate: assert (groupSel != 2'b00 || shiftOp != 2'b11 ||
        result == ((opA >> shAmt) | (shAmt == '0 ? '0 : (opA << (WIDTH - int'(shAmt))))));
      // R8 zero flag
      a_r8_zero: assert (zeroFlag == (result == '0));
    end
  end

endmodule

bind alu_top alu_top_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (.*);

// File: tb/alu_top_tb.sv
module alu_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA, opB;
  logic [4:0]  shAmt;
  logic [1:0]  logicOp, shiftOp, groupSel;
  logic        subCtl;
  logic [31:0] result;
  logic        signFlag, zeroFlag, ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu_top u_dut (
    .opA(opA), .opB(opB), .shAmt(shAmt), .logicOp(logicOp), .subCtl(subCtl),
    .shiftOp(shiftOp), .groupSel(groupSel), .result(result),
    .signFlag(signFlag), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [4:0] n,
                       input logic [1:0] lop, input logic sub, input logic [1:0] sop,
                       input logic [1:0] grp);
    @(posedge clk);
    opA = a; opB = b; shAmt = n; logicOp = lop; subCtl = sub; shiftOp = sop; groupSel = grp;
    @(negedge clk);
  endtask

  function automatic logic [31:0] shiftModel(input logic [31:0] a, input int n, input logic [1:0] sop);
    logic [63:0] dbl;
    dbl = {a, a} >> n;
    case (sop)
      2'b00:   return a << n;
      2'b01:   return a >> n;
      2'b10:   return 32'($signed(a) >>> n);
      default: return dbl[31:0];
    endcase
  endfunction

  // adder expectations for A op B (sub=1 subtract)
  task automatic addModel(input logic [31:0] a, input logic [31:0] b, input logic sub,
                          output logic [31:0] r, output logic ov);
    longint sa, sb, s;
    sa = $signed(a);
    sb = $signed(b);
    s  = sub ? sa - sb : sa + sb;
    r  = 32'(s);
    ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endtask

  logic [31:0] corner [8];
  logic [31:0] pats   [6];

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h1234_5678;
    corner[6] = 32'hFFFF_FFFE; corner[7] = 32'h8000_0001;
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hDEAD_BEEF;
    pats[3] = 32'h0000_0001; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h0F0F_00F0;

    opA = '0; opB = '0; shAmt = '0; logicOp = '0; subCtl = 1'b0; shiftOp = '0; groupSel = 2'b11;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // idle state: AND of zeros
    @(negedge clk);
    chk("R8 idle result", result, 32'h0);
    chk("R8 idle zero", {31'b0, zeroFlag}, 32'd1);

    // R1 logic group
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 4; k++) begin
          logic [31:0] e;
          case (k)
            0: e = corner[i] & corner[j];
            1: e = corner[i] | corner[j];
            2: e = ~(corner[i] | corner[j]);
            default: e = corner[i] ^ corner[j];
          endcase
          drive(corner[i], corner[j], 5'(i), 2'(k), 1'(j), 2'(k), 2'b11);
          chk("R1 logic", result, e);
          chk("R8 zero logic", {31'b0, zeroFlag}, {31'b0, e == 0});
        end

    // R2/R3/R4 arithmetic, R5 compare with both subCtl values
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int s = 0; s < 2; s++) begin
          logic [31:0] e, d;
          logic ov, dov;
          addModel(corner[i], corner[j], 1'(s), e, ov);
          drive(corner[i], corner[j], 5'd3, 2'b01, 1'(s), 2'b10, 2'b10);
          chk("R2 arith", result, e);
          chk("R3 overflow", {31'b0, ovfFlag}, {31'b0, ov});
          chk("R4 sign", {31'b0, signFlag}, {31'b0, e[31]});
          chk("R8 zero arith", {31'b0, zeroFlag}, {31'b0, e == 0});

          addModel(corner[i], corner[j], 1'b1, d, dov);
          drive(corner[i], corner[j], 5'd7, 2'b10, 1'(s), 2'b01, 2'b01);
          chk("R5 slt", result, {31'b0, $signed(corner[i]) < $signed(corner[j])});
          chk("R3 slt overflow", {31'b0, ovfFlag}, {31'b0, dov});
          chk("R4 slt sign", {31'b0, signFlag}, {31'b0, d[31]});
          chk("R8 zero slt", {31'b0, zeroFlag},
              {31'b0, !($signed(corner[i]) < $signed(corner[j]))});
        end

    // R6/R7/R9 shift sweep: every distance, every kind; opB, subCtl, logicOp varied
    for (int p = 0; p < 6; p++)
      for (int op = 0; op < 4; op++)
        for (int n = 0; n < 32; n++) begin
          logic [31:0] e;
          e = shiftModel(pats[p], n, 2'(op));
          drive(pats[p], ~pats[p] ^ 32'(n * 77), 5'(n), 2'(n), 1'(n), 2'(op), 2'b00);
          if (op == 0) chk("R6 sll", result, e);
          else         chk("R7 right/rotate", result, e);
          chk("R8 zero shift", {31'b0, zeroFlag}, {31'b0, e == 0});
        end

    // R9 explicit: same shift with different opB/subCtl/logicOp
    drive(32'hA5A5_0F0F, 32'h0, 5'd9, 2'b00, 1'b0, 2'b10, 2'b00);
    chk("R9 baseline", result, shiftModel(32'hA5A5_0F0F, 9, 2'b10));
    drive(32'hA5A5_0F0F, 32'hFFFF_FFFF, 5'd9, 2'b11, 1'b1, 2'b10, 2'b00);
    chk("R9 opB/subCtl ignored", result, shiftModel(32'hA5A5_0F0F, 9, 2'b10));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule